// File: doc/BRIEF.md
# Interval Timer Count Latch and Read-Back Controller

This block sits beside three 16-bit down-counters of an AT-style interval timer and owns everything between their live state and the byte-wide read bus. It decodes byte writes to the timer's control port into count-latch commands, multi-counter read-back commands and per-counter reprogramming. For each counter it keeps a count latch and a status latch. Each latch is loaded once and then ignores further requests until it has been read out.

A read from a counter port returns a byte chosen by that counter's state. A pending status byte comes first. After it comes the latched count, or the live count when no count is latched. The count bytes follow the counter's programmed byte-access order. Once the last byte of a latched count has been read, the counter goes transparent again. Reprogramming a counter drops its latches and restarts its byte order.

The counting engines are outside the block. It only watches their live count, their OUT level, their null-count flag and a 4-bit configuration field that holds the mode and the BCD flag.

Top module: `tmr_latch_rb`

## Requirements
- R1: After reset no latch is pending, every counter uses low-then-high access with the pointer on the low byte, and reads return the live count.
- R2: A control write with bits 7:6 = counter number (0 to 2) and bits 5:4 = 00 latches that counter's count as sampled at the write's clock edge. Later reads return the frozen value while the live count moves on.
- R3: A count-latch request (plain or read-back) to a counter whose latched count is not yet fully read is ignored, and the first value is kept.
- R4: Each counter's latches are independent. Several counters may be latched in turn and read in any order.
- R5: A read-back command has bits 7:6 = 11. Bits 1, 2 and 3 select counters 0, 1 and 2 in any combination, and bit 0 has no effect. Bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch, on every selected counter.
- R6: The status byte is {OUT level (bit 7), null-count flag (bit 6), access code (bits 5:4), configuration field (bits 3:0)}, sampled at the command's edge.
- R7: When status is latched, the next read of that counter returns the status byte and leaves the count byte pointer and count latch unchanged. The count follows on later reads.
- R8: A status-latch request on a counter whose latched status is unread is ignored.
- R9: The access code sets the count byte order: 01 returns the low byte only, 10 returns the high byte only, and 11 returns low then high. A latched count is released after its last byte is read.
- R10: A control write with bits 7:6 = counter number and bits 5:4 != 00 stores bits 5:4 as the access code, clears that counter's pending count and status latches, and returns its pointer to the low byte.
- R11: A read with port select 3 returns 0x00 and changes no counter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 8 | Control-port write byte |
| rd_en | input | 1 | Read strobe, consumed at the clock edge |
| rd_sel | input | 2 | Counter port being read (0 to 2; 3 is unused) |
| rd_data | output | 8 | Byte presented for the selected port |
| live_cnt | input | 48 | Live counts, counter k in bits 16k+15:16k |
| live_out | input | 3 | OUT level per counter |
| live_null | input | 3 | Null-count flag per counter |
| live_cfg | input | 12 | Mode and BCD field per counter, counter k in bits 4k+3:4k |

## Verification
`rd_data` is a combinational view of the current latch state, so a byte responds within the same cycle to `rd_sel` and to live inputs. A write or read strobe takes effect at the next rising edge, and its result shows on `rd_data` from the cycle after. The bench drives every input at the falling edge and compares `rd_data` with its model 1 ns later. It then advances the model by the effect of that cycle's strobes, so each comparison sees exactly the edges the design has taken.

// File: rtl/tmr_latch_rb_pkg.sv
package tmr_latch_rb_pkg;
   // Byte-access code carried in control bits 5:4
   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_LOHI = 2'b11
   } acc_e;

   // Counter-field value that marks a read-back command
   localparam logic [1:0] SEL_MULTI = 2'b11;
endpackage

// File: rtl/tmr_rb_decode.sv
module tmr_rb_decode
   import tmr_latch_rb_pkg::*;
#(
   parameter int NUM_CTR = 3,
   parameter int BYTE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [BYTE_W-1:0]  ctl_data,
   output logic [NUM_CTR-1:0] lat_cnt,
   output logic [NUM_CTR-1:0] lat_sts,
   output logic [NUM_CTR-1:0] reprog,
   output acc_e               new_acc
);
   logic [1:0] ctr_field;
   logic [1:0] acc_field;
   logic       is_multi;
   logic       unused_rsvd;

   assign ctr_field   = ctl_data[7:6];
   assign acc_field   = ctl_data[5:4];
   assign is_multi    = (ctr_field == SEL_MULTI);
   assign new_acc     = acc_e'(acc_field);
   assign unused_rsvd = ctl_data[0];

   always_comb begin
      lat_cnt = '0;
      lat_sts = '0;
      reprog  = '0;
      if (ctl_wr) begin
         for (int i = 0; i < NUM_CTR; i++) begin
            if (is_multi) begin
               lat_cnt[i] = ctl_data[i+1] & ~ctl_data[5];
               lat_sts[i] = ctl_data[i+1] & ~ctl_data[4];
            end else if (ctr_field == 2'(i)) begin
               if (acc_field == ACC_NONE) lat_cnt[i] = 1'b1;
               else                       reprog[i]  = 1'b1;
            end
         end
      end
   end

   // R10
   reprog_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reprog));
   // R5
   multi_no_reprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && is_multi) |-> (reprog == '0));
endmodule

// File: rtl/tmr_rb_lane.sv
module tmr_rb_lane
   import tmr_latch_rb_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CFG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reprog,
   input  acc_e              new_acc,
   input  logic              lat_cnt,
   input  logic              lat_sts,
   input  logic              rd,
   input  logic [CNT_W-1:0]  live_cnt,
   input  logic              live_out,
   input  logic              live_null,
   input  logic [CFG_W-1:0]  live_cfg,
   output logic [BYTE_W-1:0] rd_byte
);
   acc_e              acc_q,      acc_d;
   logic              ptr_hi_q,   ptr_hi_d;
   logic              cnt_vld_q,  cnt_vld_d;
   logic [CNT_W-1:0]  cnt_hold_q, cnt_hold_d;
   logic              sts_vld_q,  sts_vld_d;
   logic [BYTE_W-1:0] sts_hold_q, sts_hold_d;

   logic [BYTE_W-1:0] live_sts;
   logic [CNT_W-1:0]  cnt_src;
   logic [BYTE_W-1:0] cnt_byte;
   logic              hi_sel;
   logic              last_byte;

   assign live_sts  = {live_out, live_null, acc_q, live_cfg};
   assign cnt_src   = cnt_vld_q ? cnt_hold_q : live_cnt;
   assign hi_sel    = (acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && ptr_hi_q);
   assign cnt_byte  = hi_sel ? cnt_src[CNT_W-1 -: BYTE_W] : cnt_src[BYTE_W-1:0];
   assign rd_byte   = sts_vld_q ? sts_hold_q : cnt_byte;
   assign last_byte = (acc_q != ACC_LOHI) || ptr_hi_q;

   always_comb begin
      acc_d      = acc_q;
      ptr_hi_d   = ptr_hi_q;
      cnt_vld_d  = cnt_vld_q;
      cnt_hold_d = cnt_hold_q;
      sts_vld_d  = sts_vld_q;
      sts_hold_d = sts_hold_q;
      if (reprog) begin
         acc_d     = new_acc;
         ptr_hi_d  = 1'b0;
         cnt_vld_d = 1'b0;
         sts_vld_d = 1'b0;
      end else begin
         if (rd) begin
            if (sts_vld_q) begin
               sts_vld_d = 1'b0;
            end else begin
               if (acc_q == ACC_LOHI) ptr_hi_d = ~ptr_hi_q;
               if (last_byte)         cnt_vld_d = 1'b0;
            end
         end
         if (lat_cnt && !cnt_vld_q) begin
            cnt_vld_d  = 1'b1;
            cnt_hold_d = live_cnt;
         end
         if (lat_sts && !sts_vld_q) begin
            sts_vld_d  = 1'b1;
            sts_hold_d = live_sts;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= ACC_LOHI;
         ptr_hi_q   <= 1'b0;
         cnt_vld_q  <= 1'b0;
         cnt_hold_q <= '0;
         sts_vld_q  <= 1'b0;
         sts_hold_q <= '0;
      end else begin
         acc_q      <= acc_d;
         ptr_hi_q   <= ptr_hi_d;
         cnt_vld_q  <= cnt_vld_d;
         cnt_hold_q <= cnt_hold_d;
         sts_vld_q  <= sts_vld_d;
         sts_hold_q <= sts_hold_d;
      end
   end

   // R3
   cnt_latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_vld_q && lat_cnt && !rd && !reprog) |=> (cnt_vld_q && $stable(cnt_hold_q)));
   // R8
   sts_latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_vld_q && lat_sts && !rd && !reprog) |=> (sts_vld_q && $stable(sts_hold_q)));
   // R7
   sts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_vld_q && rd && !reprog && !lat_cnt) |=>
         (!sts_vld_q && $stable(ptr_hi_q) && $stable(cnt_vld_q)));
   // R10
   reprog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reprog |=> (!cnt_vld_q && !sts_vld_q && !ptr_hi_q));
   // R9
   lohi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !sts_vld_q && !reprog && acc_q == ACC_LOHI) |=> (ptr_hi_q != $past(ptr_hi_q)));
endmodule

// File: rtl/tmr_rb_rdmux.sv
module tmr_rb_rdmux #(
   parameter int NUM_CTR = 3,
   parameter int BYTE_W  = 8,
   parameter int SEL_W   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic [SEL_W-1:0]                rd_sel,
   input  logic [NUM_CTR-1:0][BYTE_W-1:0]  lane_byte,
   output logic [NUM_CTR-1:0]              rd_stb,
   output logic [BYTE_W-1:0]               rd_data
);
   always_comb begin
      rd_stb  = '0;
      rd_data = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (rd_sel == SEL_W'(i)) begin
            rd_stb[i] = rd_en;
            rd_data   = lane_byte[i];
         end
      end
   end

   // R11
   idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel >= SEL_W'(NUM_CTR)) |-> (rd_stb == '0 && rd_data == '0));
endmodule

// File: rtl/tmr_latch_rb.sv
module tmr_latch_rb
   import tmr_latch_rb_pkg::*;
#(
   parameter int NUM_CTR = 3,
   parameter int CNT_W   = 16,
   parameter int BYTE_W  = 8,
   parameter int CFG_W   = 4,
   localparam int SEL_W  = $clog2(NUM_CTR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_wr,
   input  logic [BYTE_W-1:0]        ctl_data,
   input  logic                     rd_en,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [BYTE_W-1:0]        rd_data,
   input  logic [NUM_CTR*CNT_W-1:0] live_cnt,
   input  logic [NUM_CTR-1:0]       live_out,
   input  logic [NUM_CTR-1:0]       live_null,
   input  logic [NUM_CTR*CFG_W-1:0] live_cfg
);
   initial begin
      assert (NUM_CTR == 3) else $error("command format fixes three counters");
      assert (CNT_W == 2 * BYTE_W) else $error("count must be two bytes wide");
      assert (CFG_W + 4 == BYTE_W) else $error("status fields must fill one byte");
   end

   logic [NUM_CTR-1:0]             lat_cnt;
   logic [NUM_CTR-1:0]             lat_sts;
   logic [NUM_CTR-1:0]             reprog;
   logic [NUM_CTR-1:0]             rd_stb;
   acc_e                           new_acc;
   logic [NUM_CTR-1:0][BYTE_W-1:0] lane_byte;

   tmr_rb_decode #(.NUM_CTR(NUM_CTR), .BYTE_W(BYTE_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_data (ctl_data),
      .lat_cnt  (lat_cnt),
      .lat_sts  (lat_sts),
      .reprog   (reprog),
      .new_acc  (new_acc)
   );

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_lane
      tmr_rb_lane #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .CFG_W(CFG_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .reprog    (reprog[g]),
         .new_acc   (new_acc),
         .lat_cnt   (lat_cnt[g]),
         .lat_sts   (lat_sts[g]),
         .rd        (rd_stb[g]),
         .live_cnt  (live_cnt[g*CNT_W +: CNT_W]),
         .live_out  (live_out[g]),
         .live_null (live_null[g]),
         .live_cfg  (live_cfg[g*CFG_W +: CFG_W]),
         .rd_byte   (lane_byte[g])
      );
   end

   tmr_rb_rdmux #(.NUM_CTR(NUM_CTR), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_sel    (rd_sel),
      .lane_byte (lane_byte),
      .rd_stb    (rd_stb),
      .rd_data   (rd_data)
   );
endmodule

// File: tb/tmr_latch_rb_test.sv
`timescale 1ns/1ps
module tmr_latch_rb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_data = 8'h00;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_sel = 2'd0;
   logic [7:0]  rd_data;
   logic [15:0] lc [3];
   logic [47:0] live_cnt;
   logic [2:0]  live_out;
   logic [2:0]  live_null = 3'b010;
   logic [11:0] live_cfg = 12'h5A3;

   assign live_cnt = {lc[2], lc[1], lc[0]};
   assign live_out = {lc[2][5], lc[1][5], lc[0][5]};

   always #4 clk = ~clk;

   tmr_latch_rb uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .live_cnt(live_cnt), .live_out(live_out), .live_null(live_null),
      .live_cfg(live_cfg)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   // reference model state
   logic [1:0]  m_acc [3];
   logic        m_ptr [3];
   logic        m_cv  [3];
   logic [15:0] m_ch  [3];
   logic        m_sv  [3];
   logic [7:0]  m_sh  [3];

   function automatic logic [7:0] expect_byte(input int k);
      logic [15:0] src;
      if (k == 3) return 8'h00;
      if (m_sv[k]) return m_sh[k];
      src = m_cv[k] ? m_ch[k] : lc[k];
      if (m_acc[k] == 2'b10 || (m_acc[k] == 2'b11 && m_ptr[k])) return src[15:8];
      return src[7:0];
   endfunction

   task automatic model_update();
      bit want_c [3];
      bit want_s [3];
      bit redo   [3];
      for (int k = 0; k < 3; k++) begin
         want_c[k] = 0; want_s[k] = 0; redo[k] = 0;
      end
      if (ctl_wr) begin
         if (ctl_data[7:6] == 2'b11) begin
            for (int k = 0; k < 3; k++)
               if (ctl_data[k+1]) begin
                  want_c[k] = !ctl_data[5];
                  want_s[k] = !ctl_data[4];
               end
         end else if (ctl_data[5:4] == 2'b00) begin
            want_c[ctl_data[7:6]] = 1;
         end else begin
            redo[ctl_data[7:6]] = 1;
         end
      end
      for (int k = 0; k < 3; k++) begin
         bit cv0 = m_cv[k];
         bit sv0 = m_sv[k];
         logic [7:0] st = {live_out[k], live_null[k], m_acc[k], live_cfg[k*4 +: 4]};
         if (redo[k]) begin
            m_acc[k] = ctl_data[5:4]; m_ptr[k] = 0; m_cv[k] = 0; m_sv[k] = 0;
         end else begin
            if (rd_en && rd_sel == 2'(k)) begin
               if (sv0) m_sv[k] = 0;
               else begin
                  bit fin = (m_acc[k] != 2'b11) || m_ptr[k];
                  if (m_acc[k] == 2'b11) m_ptr[k] = !m_ptr[k];
                  if (fin) m_cv[k] = 0;
               end
            end
            if (want_c[k] && !cv0) begin m_cv[k] = 1; m_ch[k] = lc[k]; end
            if (want_s[k] && !sv0) begin m_sv[k] = 1; m_sh[k] = st; end
         end
      end
   endtask

   // one bus cycle: drive, compare, then advance the model past the next edge
   task automatic step(input bit w, input logic [7:0] wd, input bit r,
                       input logic [1:0] rs, input string tag);
      logic [7:0] exp_b;
      @(negedge clk);
      ctl_wr = w; ctl_data = wd; rd_en = r; rd_sel = rs;
      for (int k = 0; k < 3; k++) lc[k] = lc[k] - 16'(3*k + 1);
      #1;
      exp_b = expect_byte(int'(rs));
      checks++;
      if (rd_data !== exp_b) begin
         errors++;
         $display("FAIL %s: port %0d rd_data=%h expected %h", tag, rs, rd_data, exp_b);
      end
      model_update();
   endtask

   task automatic rd(input logic [1:0] rs, input string tag);
      step(0, 8'h00, 1, rs, tag);
   endtask

   task automatic cmd(input logic [7:0] wd, input string tag);
      step(1, wd, 0, 2'd0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected under 20000", cyc);
         finish_run();
      end
   end

   initial begin
      lc[0] = 16'h1234; lc[1] = 16'hA5C3; lc[2] = 16'h0F80;
      for (int k = 0; k < 3; k++) begin
         m_acc[k] = 2'b11; m_ptr[k] = 0; m_cv[k] = 0; m_ch[k] = 0; m_sv[k] = 0; m_sh[k] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: transparent reads after reset, low then high
      step(0, 8'h00, 0, 2'd0, "R1");
      rd(2'd0, "R1"); rd(2'd0, "R1"); rd(2'd1, "R1"); step(0, 8'h00, 0, 2'd2, "R1");

      // R2: latch counter 0, value stays frozen
      cmd(8'h00, "R2");
      step(0, 8'h00, 0, 2'd0, "R2"); step(0, 8'h00, 0, 2'd0, "R2");
      rd(2'd0, "R2"); rd(2'd0, "R2"); rd(2'd0, "R2");
      rd(2'd0, "R2");

      // R3: repeated latches ignored, also between the two bytes
      cmd(8'h00, "R3"); cmd(8'h00, "R3");
      rd(2'd0, "R3"); cmd(8'h00, "R3"); cmd(8'hD2, "R3");
      rd(2'd0, "R3"); rd(2'd0, "R3"); rd(2'd0, "R3");

      // R4: independent latches on all counters
      cmd(8'h40, "R4"); cmd(8'h80, "R4"); cmd(8'h00, "R4");
      step(0, 8'h00, 0, 2'd1, "R4");
      rd(2'd2, "R4"); rd(2'd2, "R4"); rd(2'd0, "R4"); rd(2'd0, "R4");
      rd(2'd1, "R4"); rd(2'd1, "R4"); rd(2'd1, "R4");

      // R5 R6 R7: read-back of status and count on all counters
      cmd(8'hCE, "R5");
      rd(2'd1, "R6"); rd(2'd1, "R7"); rd(2'd1, "R7");
      rd(2'd0, "R6"); rd(2'd0, "R7"); rd(2'd0, "R7");
      rd(2'd2, "R6"); rd(2'd2, "R7"); rd(2'd2, "R7"); rd(2'd2, "R7");
      // R5: bit 0 ignored, only counter 1 selected
      cmd(8'hC5, "R5");
      rd(2'd0, "R5"); rd(2'd0, "R5");
      rd(2'd1, "R5"); rd(2'd1, "R5"); rd(2'd1, "R5");
      // R5: count-only and nothing-selected forms
      cmd(8'hD2, "R5"); rd(2'd0, "R5"); rd(2'd0, "R5");
      cmd(8'hFE, "R5"); rd(2'd1, "R5"); rd(2'd1, "R5");

      // R7: status read leaves pointer on high byte
      rd(2'd2, "R7"); cmd(8'hE8, "R7"); rd(2'd2, "R7"); rd(2'd2, "R7"); rd(2'd2, "R7");

      // R8: repeated status latch ignored while live OUT moves
      cmd(8'hE8, "R8");
      repeat (10) step(0, 8'h00, 0, 2'd2, "R8");
      cmd(8'hE8, "R8");
      rd(2'd2, "R8"); rd(2'd2, "R8");

      // R9 R10: low-only and high-only access orders
      cmd(8'h50, "R10");
      rd(2'd1, "R9"); rd(2'd1, "R9"); cmd(8'h40, "R9"); rd(2'd1, "R9"); rd(2'd1, "R9");
      cmd(8'hA0, "R10");
      rd(2'd2, "R9"); cmd(8'h80, "R9"); step(0, 8'h00, 0, 2'd2, "R9");
      rd(2'd2, "R9"); rd(2'd2, "R9");

      // R10: reprogram drops pending latches and resets pointer
      cmd(8'hCE, "R10"); cmd(8'hB0, "R10"); rd(2'd2, "R10"); rd(2'd2, "R10");
      rd(2'd0, "R10"); rd(2'd0, "R10"); rd(2'd0, "R10");
      cmd(8'h30, "R10"); rd(2'd0, "R10"); rd(2'd0, "R10");

      // R11: unused port reads zero and touches nothing
      cmd(8'hC2, "R11");
      rd(2'd3, "R11"); rd(2'd3, "R11"); step(0, 8'h00, 0, 2'd3, "R11");
      rd(2'd0, "R11"); rd(2'd0, "R11"); rd(2'd0, "R11");

      step(0, 8'h00, 0, 2'd0, "R1");
      finish_run();
   end
endmodule